// File: doc/BRIEF.md
# Register-Stack Divide Sequencer

This block is the control path for a floating-point divide that reads its operands from an eight-entry register stack. The stack entries are named relative to a 3-bit top pointer, and each entry carries a valid tag. An operation gives a form code, a register index and a pop request. From these the block works out which entry is the dividend, which is the divisor (an entry or a memory value), and which entry receives the quotient. It then hands the two operands to an external divide unit and waits for it to finish.

When the divide unit finishes, the block writes the quotient back, unless the unit reports a zero-divide fault that is not masked. In the same cycle it may also pop the stack. If an operand entry is empty, the operation is refused as a stack underflow. In that case no request is issued and the stack is left as it was. A faulted operation is treated the same way: the stack is left untouched, so the operation can be retried. A load port pushes values onto the stack.

Top module: `fstk_div_seq`

## Requirements
- R1: After reset the top pointer is 0, all eight tags are empty, `busy` is 0 and `fin_valid` is 0.
- R2: A load (`ld_valid`) taken while idle with no `op_valid` lowers the top pointer by one, stores `ld_data` as the new ST(0) and marks it valid. A load is dropped while busy, and it is also dropped in a cycle where `op_valid` is high.
- R3: ST(i) is physical entry (top + i) mod 8. The read port returns the data and tag of ST(`rd_idx`).
- R4: The form codes behave as follows:
  - Form 0 computes ST(1)/ST(0) into ST(1) and always pops.
  - Form 1 computes ST(0)/`mem_value` into ST(0) and never pops.
  - Form 2 computes ST(0)/ST(i) into ST(0) and never pops.
  - Form 3 computes ST(i)/ST(0) into ST(i) and pops only when `op_pop` is 1.
  
  Here i is `op_idx`, and `op_pop` is ignored for forms 0 to 2.
- R5: In the cycle after an operation is taken, `div_req` is high for exactly one cycle, with `div_a` = dividend and `div_b` = divisor. `busy` is high from that cycle until completion.
- R6: `op_valid` while busy has no effect: there is no new request and no change to the stack.
- R7: A pop marks the old ST(0) empty and adds one to the top pointer (mod 8). The pop happens in the same cycle as the write-back. If the destination is the old ST(0), that entry ends empty.
- R8: If any operand register read by the form is empty, then in the next cycle `fin_valid` and `fin_uflow` are 1 and `c1` is 0. No request is issued and the stack is unchanged.
- R9: `div_fault` together with `div_done` cancels both the write-back and the pop. It also gives `fin_zdiv` = 1 and `c1` = 0.
- R10: `fin_valid` pulses in the cycle after `div_done`. On success `c1` takes `div_rnd_up`, and the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request |
| op_form | input | 2 | Operand form code (0..3) |
| op_idx | input | 3 | Register index i |
| op_pop | input | 1 | Pop request for form 3 |
| mem_value | input | 16 | Memory divisor for form 1 |
| ld_valid | input | 1 | Push request |
| ld_data | input | 16 | Value to push |
| busy | output | 1 | Divide in flight |
| div_req | output | 1 | Request pulse to divide unit |
| div_a | output | 16 | Dividend |
| div_b | output | 16 | Divisor |
| div_done | input | 1 | Divide unit finished |
| div_result | input | 16 | Quotient |
| div_fault | input | 1 | Unmasked zero-divide fault |
| div_rnd_up | input | 1 | Quotient was rounded up |
| fin_valid | output | 1 | Operation completed or refused |
| fin_uflow | output | 1 | Stack underflow on this completion |
| fin_zdiv | output | 1 | Zero-divide fault on this completion |
| c1 | output | 1 | Condition bit C1 |
| top_out | output | 3 | Top pointer |
| tag_out | output | 8 | Physical valid tags |
| rd_idx | input | 3 | Relative read index |
| rd_data | output | 16 | Data of ST(rd_idx) |
| rd_tag | output | 1 | Tag of ST(rd_idx) |

## Verification
The quotient write-back and the pop land on the same clock edge. With form 3 and index 0, that edge both sets and clears the same entry's tag. With form 0, it writes ST(1) while emptying ST(0). The bench provokes these cases by sweeping every form, index and pop setting over stack depths 0 to 8. After each operation it reads back every relative entry and the top pointer and compares them with a stack model kept in the bench. A second sweep places a zero at ST(0) and in the memory value. This checks that the fault case suppresses both actions in that same cycle.

// File: rtl/fstk_pkg.sv
package fstk_pkg;
    localparam int DATA_W    = 16;
    localparam int STK_DEPTH = 8;
    localparam int PTR_W     = $clog2(STK_DEPTH);

    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        FORM_BARE     = 2'd0,
        FORM_MEM      = 2'd1,
        FORM_INTO_TOP = 2'd2,
        FORM_INTO_REG = 2'd3
    } form_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_e;

    typedef struct packed {
        ptr_t num_slot;
        ptr_t den_slot;
        ptr_t dst_slot;
        logic den_mem;
        logic pop;
    } plan_t;

    function automatic ptr_t slot_of(input ptr_t top, input ptr_t rel);
        return ptr_t'(top + rel);
    endfunction
endpackage

// File: rtl/fstk_decode.sv
module fstk_decode
    import fstk_pkg::*;
(
    input  form_e                form,
    input  ptr_t                 idx,
    input  logic                 pop_req,
    input  ptr_t                 top,
    input  logic [STK_DEPTH-1:0] tags,
    output plan_t                plan,
    output logic                 uflow
);
    ptr_t s0, s1, si;

    always_comb begin
        s0 = top;
        s1 = slot_of(top, ptr_t'(1));
        si = slot_of(top, idx);
        plan = '0;
        uflow = 1'b0;
        case (form)
            FORM_BARE: begin
                plan.num_slot = s1;
                plan.den_slot = s0;
                plan.dst_slot = s1;
                plan.pop      = 1'b1;
                uflow = !tags[s0] || !tags[s1];
            end
            FORM_MEM: begin
                plan.num_slot = s0;
                plan.den_slot = s0;
                plan.dst_slot = s0;
                plan.den_mem  = 1'b1;
                uflow = !tags[s0];
            end
            FORM_INTO_TOP: begin
                plan.num_slot = s0;
                plan.den_slot = si;
                plan.dst_slot = s0;
                uflow = !tags[s0] || !tags[si];
            end
            FORM_INTO_REG: begin
                plan.num_slot = si;
                plan.den_slot = s0;
                plan.dst_slot = si;
                plan.pop      = pop_req;
                uflow = !tags[s0] || !tags[si];
            end
            default: begin
                plan = '0;
                uflow = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fstk_stack.sv
module fstk_stack
    import fstk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 push_en,
    input  word_t                push_data,
    input  logic                 wr_en,
    input  ptr_t                 wr_slot,
    input  word_t                wr_data,
    input  logic                 pop_en,
    input  ptr_t                 rd_slot_a,
    input  ptr_t                 rd_slot_b,
    input  ptr_t                 rd_rel,
    output word_t                rd_a,
    output word_t                rd_b,
    output word_t                rd_rel_data,
    output logic                 rd_rel_tag,
    output ptr_t                 top,
    output logic [STK_DEPTH-1:0] tags
);
    word_t store [STK_DEPTH];
    ptr_t  below;
    ptr_t  rel_slot;

    assign below    = ptr_t'(top - ptr_t'(1));
    assign rel_slot = slot_of(top, rd_rel);

    always_ff @(posedge clk) begin
        if (rst) begin
            top  <= '0;
            tags <= '0;
        end else if (push_en) begin
            top         <= below;
            tags[below] <= 1'b1;
        end else begin
            if (wr_en)
                tags[wr_slot] <= 1'b1;
            if (pop_en) begin
                tags[top] <= 1'b0;
                top       <= slot_of(top, ptr_t'(1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_en)
            store[below] <= push_data;
        else if (wr_en)
            store[wr_slot] <= wr_data;
    end

    assign rd_a        = store[rd_slot_a];
    assign rd_b        = store[rd_slot_b];
    assign rd_rel_data = store[rel_slot];
    assign rd_rel_tag  = tags[rel_slot];

    // R2: a push lowers the pointer and validates the new top entry
    a_r2_push_lowers: assert property (@(posedge clk) disable iff (rst)
        push_en |=> (top == ptr_t'($past(top) - 1)) && tags[top]);

    // R7: a pop advances the pointer and leaves the old top empty
    a_r7_pop_advances: assert property (@(posedge clk) disable iff (rst)
        (pop_en && !push_en) |=> (top == ptr_t'($past(top) + 1)) && !tags[$past(top)]);
endmodule

// File: rtl/fstk_div_seq.sv
module fstk_div_seq
    import fstk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 op_valid,
    input  logic [1:0]           op_form,
    input  logic [PTR_W-1:0]     op_idx,
    input  logic                 op_pop,
    input  logic [DATA_W-1:0]    mem_value,
    input  logic                 ld_valid,
    input  logic [DATA_W-1:0]    ld_data,
    output logic                 busy,
    output logic                 div_req,
    output logic [DATA_W-1:0]    div_a,
    output logic [DATA_W-1:0]    div_b,
    input  logic                 div_done,
    input  logic [DATA_W-1:0]    div_result,
    input  logic                 div_fault,
    input  logic                 div_rnd_up,
    output logic                 fin_valid,
    output logic                 fin_uflow,
    output logic                 fin_zdiv,
    output logic                 c1,
    output logic [PTR_W-1:0]     top_out,
    output logic [STK_DEPTH-1:0] tag_out,
    input  logic [PTR_W-1:0]     rd_idx,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_tag
);
    seq_e  state;
    plan_t plan;
    logic  dec_uflow;
    ptr_t  dst_q;
    logic  pop_q;
    word_t a_q, b_q;
    word_t rd_a, rd_b;
    logic  accept, push_en, wr_en, pop_en;

    fstk_decode u_dec (
        .form    (form_e'(op_form)),
        .idx     (op_idx),
        .pop_req (op_pop),
        .top     (top_out),
        .tags    (tag_out),
        .plan    (plan),
        .uflow   (dec_uflow)
    );

    assign accept  = (state == SEQ_IDLE) && op_valid;
    assign push_en = (state == SEQ_IDLE) && ld_valid && !op_valid;
    assign wr_en   = (state == SEQ_WAIT) && div_done && !div_fault;
    assign pop_en  = wr_en && pop_q;

    fstk_stack u_stk (
        .clk         (clk),
        .rst         (rst),
        .push_en     (push_en),
        .push_data   (ld_data),
        .wr_en       (wr_en),
        .wr_slot     (dst_q),
        .wr_data     (div_result),
        .pop_en      (pop_en),
        .rd_slot_a   (plan.num_slot),
        .rd_slot_b   (plan.den_slot),
        .rd_rel      (rd_idx),
        .rd_a        (rd_a),
        .rd_b        (rd_b),
        .rd_rel_data (rd_data),
        .rd_rel_tag  (rd_tag),
        .top         (top_out),
        .tags        (tag_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_IDLE;
            div_req   <= 1'b0;
            fin_valid <= 1'b0;
            fin_uflow <= 1'b0;
            fin_zdiv  <= 1'b0;
            c1        <= 1'b0;
            dst_q     <= '0;
            pop_q     <= 1'b0;
            a_q       <= '0;
            b_q       <= '0;
        end else begin
            div_req   <= 1'b0;
            fin_valid <= 1'b0;
            fin_uflow <= 1'b0;
            fin_zdiv  <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (accept) begin
                        if (dec_uflow) begin
                            fin_valid <= 1'b1;
                            fin_uflow <= 1'b1;
                            c1        <= 1'b0;
                        end else begin
                            state   <= SEQ_WAIT;
                            div_req <= 1'b1;
                            a_q     <= rd_a;
                            b_q     <= plan.den_mem ? mem_value : rd_b;
                            dst_q   <= plan.dst_slot;
                            pop_q   <= plan.pop;
                        end
                    end
                end
                SEQ_WAIT: begin
                    if (div_done) begin
                        state     <= SEQ_IDLE;
                        fin_valid <= 1'b1;
                        fin_zdiv  <= div_fault;
                        c1        <= div_fault ? 1'b0 : div_rnd_up;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign busy  = (state == SEQ_WAIT);
    assign div_a = a_q;
    assign div_b = b_q;

    // R5: the request is a single-cycle pulse raised only while busy
    a_r5_req_single: assert property (@(posedge clk) disable iff (rst)
        div_req |=> !div_req);
    a_r5_req_busy: assert property (@(posedge clk) disable iff (rst)
        div_req |-> busy);

    // R6: a request while busy starts nothing
    a_r6_busy_ignores: assert property (@(posedge clk) disable iff (rst)
        (busy && op_valid && !div_done) |=> busy && !div_req);

    // R8: an underflow is refused without a request
    a_r8_uflow_refused: assert property (@(posedge clk) disable iff (rst)
        (!busy && op_valid && dec_uflow) |=> fin_uflow && !div_req && !busy && !c1);

    // R9: a faulted completion leaves pointer and tags alone
    a_r9_fault_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && div_done && div_fault) |=> (top_out == $past(top_out)) && (tag_out == $past(tag_out)) && fin_zdiv);
endmodule

// File: tb/fstk_div_seq_test.sv
module fstk_div_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_form = 2'd0;
    logic [2:0]  op_idx = 3'd0;
    logic        op_pop = 1'b0;
    logic [15:0] mem_value = 16'd0;
    logic        ld_valid = 1'b0;
    logic [15:0] ld_data = 16'd0;
    logic        busy, div_req;
    logic [15:0] div_a, div_b;
    logic        div_done = 1'b0;
    logic [15:0] div_result = 16'd0;
    logic        div_fault = 1'b0;
    logic        div_rnd_up = 1'b0;
    logic        fin_valid, fin_uflow, fin_zdiv, c1;
    logic [2:0]  top_out;
    logic [7:0]  tag_out;
    logic [2:0]  rd_idx = 3'd0;
    logic [15:0] rd_data;
    logic        rd_tag;

    int total = 0;
    int bad = 0;
    int m_val [8];
    bit m_tag [8];
    int m_top = 0;

    always #4 clk = ~clk;

    fstk_div_seq uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_form(op_form),
        .op_idx(op_idx), .op_pop(op_pop), .mem_value(mem_value),
        .ld_valid(ld_valid), .ld_data(ld_data), .busy(busy),
        .div_req(div_req), .div_a(div_a), .div_b(div_b),
        .div_done(div_done), .div_result(div_result), .div_fault(div_fault),
        .div_rnd_up(div_rnd_up), .fin_valid(fin_valid), .fin_uflow(fin_uflow),
        .fin_zdiv(fin_zdiv), .c1(c1), .top_out(top_out), .tag_out(tag_out),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_tag(rd_tag)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_top = 0;
        for (int s = 0; s < 8; s++) begin
            m_tag[s] = 1'b0;
            m_val[s] = 0;
        end
    endtask

    function automatic int ph(input int rel);
        return (m_top + rel) % 8;
    endfunction

    task automatic check_stack(input string rq);
        check(int'(top_out) == m_top, rq, int'(top_out), m_top);
        for (int r = 0; r < 8; r++) begin
            rd_idx = 3'(r);
            #1;
            check(rd_tag == m_tag[ph(r)], rq, int'(rd_tag), int'(m_tag[ph(r)]));
            if (m_tag[ph(r)])
                check(int'(rd_data) == m_val[ph(r)], rq, int'(rd_data), m_val[ph(r)]);
        end
    endtask

    task automatic push(input int v);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_data  = 16'(v);
        @(negedge clk);
        ld_valid = 1'b0;
        m_top = (m_top + 7) % 8;
        m_val[m_top] = v;
        m_tag[m_top] = 1'b1;
    endtask

    task automatic run_op(input int form, input int idx, input bit pop, input int mem, input int lat);
        int  num_s, den_s, dst_s, a, b, res;
        bit  uf, do_pop, den_mem, fz, rnd;
        den_mem = 1'b0;
        // R4: operand selection per form code
        case (form)
            0: begin num_s = ph(1); den_s = ph(0); dst_s = ph(1); do_pop = 1'b1;
                     uf = !m_tag[ph(0)] || !m_tag[ph(1)]; end
            1: begin num_s = ph(0); den_s = ph(0); dst_s = ph(0); do_pop = 1'b0;
                     den_mem = 1'b1; uf = !m_tag[ph(0)]; end
            2: begin num_s = ph(0); den_s = ph(idx); dst_s = ph(0); do_pop = 1'b0;
                     uf = !m_tag[ph(0)] || !m_tag[ph(idx)]; end
            default: begin num_s = ph(idx); den_s = ph(0); dst_s = ph(idx); do_pop = pop;
                     uf = !m_tag[ph(0)] || !m_tag[ph(idx)]; end
        endcase
        a = m_val[num_s];
        b = den_mem ? mem : m_val[den_s];
        fz  = (b == 0);
        res = fz ? 0 : (a / b) & 16'hFFFF;
        rnd = fz ? 1'b0 : ((a % b) != 0);

        @(negedge clk);
        op_valid  = 1'b1;
        op_form   = 2'(form);
        op_idx    = 3'(idx);
        op_pop    = pop;
        mem_value = 16'(mem);
        ld_valid  = 1'b1;          // R2: must be dropped beside an operation
        ld_data   = 16'd999;
        @(negedge clk);
        op_valid = 1'b0;
        ld_valid = 1'b0;
        if (uf) begin
            check(fin_valid && fin_uflow, "R8 refuse", int'(fin_uflow), 1);
            check(!c1 && !div_req && !busy, "R8 no issue", int'(div_req), 0);
        end else begin
            check(div_req && busy, "R5 req", int'(div_req), 1);
            check(int'(div_a) == a, "R5 dividend", int'(div_a), a);
            check(int'(div_b) == b, "R5 divisor", int'(div_b), b);
            for (int w = 0; w < lat; w++) begin
                op_valid = 1'b1;   // R6: ignored while busy
                op_form  = 2'd0;
                ld_valid = 1'b1;
                @(negedge clk);
                check(!div_req && busy && !fin_valid, "R6 busy hold", int'(div_req), 0);
            end
            op_valid   = 1'b0;
            ld_valid   = 1'b0;
            div_done   = 1'b1;
            div_result = 16'(res);
            div_fault  = fz;
            div_rnd_up = rnd;
            @(negedge clk);
            div_done = 1'b0;
            div_fault = 1'b0;
            check(fin_valid && !busy, "R10 finish", int'(fin_valid), 1);
            check(fin_zdiv == fz, "R9 fault flag", int'(fin_zdiv), int'(fz));
            check(c1 == rnd, "R10 c1", int'(c1), int'(rnd));
            if (!fz) begin
                m_val[dst_s] = res;
                m_tag[dst_s] = 1'b1;
                if (do_pop) begin
                    m_tag[m_top] = 1'b0;
                    m_top = (m_top + 1) % 8;
                end
            end
        end
        check_stack("R3 R4 R7 R9 stack");
    endtask

    initial begin
        do_reset();
        check(top_out == 3'd0 && tag_out == 8'd0, "R1 reset stack", int'(tag_out), 0);
        check(!busy && !fin_valid, "R1 reset flags", int'(busy), 0);
        push(7);
        push(9);
        check_stack("R2 push");
        for (int z = 0; z < 2; z++)
            for (int k = 0; k <= 8; k++)
                for (int f = 0; f < 4; f++)
                    for (int i = 0; i < 8; i++)
                        for (int p = 0; p < 2; p++) begin
                            do_reset();
                            for (int j = 0; j < k; j++)
                                push((z == 1 && j == k - 1) ? 0 : 50 + 17 * j);
                            run_op(f, i, p[0], (z == 1) ? 0 : 3 + i, 1 + (i % 3));
                        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog act=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule